// File: doc/BRIEF.md
# Hardware Mutex Bank

A bank of word-wide hardware locks that lets several processors on one chip agree who owns a shared resource, such as a table in shared memory. Each lock occupies its own 4 KiB page of the address map, so a lock can be mapped into the address space of one processor only. A processor claims a lock by writing its own nonzero processor ID. It then reads the register back. If the readback equals its own ID, the processor owns the lock. Any other value means another processor got there first, and the claimant retries. The owner frees the lock by writing zero. The application processor uses ID 1 by convention.

The bank has `NUM_PORTS` independent read/write slave ports. Each port carries an address, write data, write enable, read enable and read data. Reads are combinational and have no side effects.

Each lock is a two-state machine, with `LK_FREE` holding no owner and `LK_HELD` holding a nonzero owner ID. It has these transitions:
- **CLAIM** (`LK_FREE` to `LK_HELD`): the winning write carries a nonzero ID.
- **RELEASE** (`LK_HELD` to `LK_FREE`): the winning write carries zero.
- **STAY**: every other case leaves the state and owner unchanged.

When several ports write the same lock in one cycle, the lowest-numbered port is the winning write. The other writes to that lock are dropped.

Top module: `mtx_bank`

## Requirements
- R1: Lock n is addressed at byte address n × 0x1000. The index field is `addr[ADDR_W-1:12]`, so with the default 20-bit address it is bits [19:12]. There are 32 locks, at indices 0..31.
- R2: A nonzero write to a free lock stores the written ID (CLAIM). A read of that lock in the following cycle returns the ID.
- R3: A nonzero write to a held lock is ignored, so the first writer keeps ownership.
- R4: A write of 0 clears the lock, whatever its current value and whichever port issues it (RELEASE).
- R5: When several ports write the same lock in one cycle, only the lowest-numbered port's write takes effect.
- R6: A read with read enable high returns the current owner ID, or 0 for a free lock. With read enable low the read data is 0. Reads never change any lock.
- R7: An index of 32 or more is invalid. Reads at such an index return 0, and writes to it change no lock; in particular they do not alias onto lock index mod 32.
- R8: Any address whose offset within its 4 KiB page is nonzero reads 0 and ignores writes.
- R9: After reset all 32 locks are free and read 0.
- R10: Writes from different ports to different locks in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_PORTS | Per-port write enable |
| rd_en | input | NUM_PORTS | Per-port read enable |
| addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p at bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_PORTS*DATA_W | Per-port write data (owner ID or 0) |
| rd_data | output | NUM_PORTS*DATA_W | Per-port combinational read data |

## Verification
The bench builds the bank with its defaults: two ports, 32 locks, a 20-bit address and 32-bit data. With two ports, both ports can write the same lock in one cycle, so the fixed port priority is exercised directly. The 20-bit address leaves an 8-bit index field, so indices 32 through 255 can be driven and checked for aliasing onto real locks. A behavioural model, driven by a long pseudo-random mix of claims, releases, stray offsets and invalid indices, is compared with both read ports on every cycle.

// File: rtl/hwmtx_pkg.sv
package hwmtx_pkg;
    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/mtx_decode.sv
module mtx_decode #(
    parameter int ADDR_W    = 20,
    parameter int PAGE_LG   = 12,
    parameter int NUM_LOCKS = 32,
    parameter int IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_ok,
    output logic [IDX_W-1:0]  idx
);
    localparam int FIELD_W = ADDR_W - PAGE_LG;

    logic [FIELD_W-1:0] field;

    assign field  = addr[ADDR_W-1:PAGE_LG];
    // valid only for an in-range index at page offset zero (R7, R8)
    assign hit_ok = (field < FIELD_W'(NUM_LOCKS)) && (addr[PAGE_LG-1:0] == '0);
    assign idx    = field[IDX_W-1:0];
endmodule

// File: rtl/mtx_cell.sv
module mtx_cell
    import hwmtx_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        wr_sel,
    input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0]           owner
);
    lock_state_e       state_q, state_d;
    logic [DATA_W-1:0] owner_q;
    logic              win;
    logic [DATA_W-1:0] win_data;
    logic              do_claim, do_rel;

    // fixed priority: lowest-numbered port wins (R5)
    always_comb begin
        win      = 1'b0;
        win_data = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr_sel[p]) begin
                win      = 1'b1;
                win_data = wr_data[p*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        state_d  = state_q;
        do_claim = 1'b0;
        do_rel   = 1'b0;
        unique case (state_q)
            LK_FREE: if (win && win_data != '0) begin
                state_d  = LK_HELD;
                do_claim = 1'b1;
            end
            LK_HELD: if (win && win_data == '0) begin
                state_d = LK_FREE;
                do_rel  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        owner_q <= '0;
        else if (do_claim) owner_q <= win_data;
        else if (do_rel)   owner_q <= '0;
    end

    assign owner = owner_q;

    AST_CLAIM_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_FREE && win && win_data != '0) |=> (owner_q == $past(win_data))); // R2
    AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_HELD && win && win_data != '0) |=> $stable(owner_q)); // R3
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (win && win_data == '0) |=> (owner_q == '0 && state_q == LK_FREE)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!win) |=> ($stable(owner_q) && $stable(state_q))); // R6
endmodule

// File: rtl/mtx_bank.sv
module mtx_bank
    import hwmtx_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int PAGE_LG   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        wr_en,
    input  logic [NUM_PORTS-1:0]        rd_en,
    input  logic [NUM_PORTS*ADDR_W-1:0] addr,
    input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
    output logic [NUM_PORTS*DATA_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(NUM_LOCKS);

    logic [NUM_PORTS-1:0] ok;
    logic [IDX_W-1:0]     idx [NUM_PORTS];
    logic [DATA_W-1:0]    owner_w [NUM_LOCKS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mtx_decode #(
            .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG),
            .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)
        ) i_dec (
            .addr  (addr[p*ADDR_W +: ADDR_W]),
            .hit_ok(ok[p]),
            .idx   (idx[p])
        );

        assign rd_data[p*DATA_W +: DATA_W] =
            (rd_en[p] && ok[p]) ? owner_w[idx[p]] : '0;

        AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[p] && !ok[p]) |-> (rd_data[p*DATA_W +: DATA_W] == '0)); // R7
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        logic [NUM_PORTS-1:0] sel;
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
            assign sel[p] = wr_en[p] && ok[p] && (idx[p] == IDX_W'(i));
        end

        mtx_cell #(
            .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)
        ) i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (sel),
            .wr_data(wr_data),
            .owner  (owner_w[i])
        );
    end
endmodule

// File: tb/test_mtx_bank.sv
`timescale 1ns/1ps
module test_mtx_bank;
    localparam int NP = 2;
    localparam int NL = 32;
    localparam int AW = 20;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] pwe, pre;
    logic [AW-1:0] pa [NP];
    logic [DW-1:0] pd [NP];
    logic [NP*AW-1:0] addr;
    logic [NP*DW-1:0] wr_data, rd_data;

    int checks = 0;
    int errors = 0;
    int unsigned mdl [NL];

    always #10 clk = ~clk;

    for (genvar p = 0; p < NP; p++) begin : g_flat
        assign addr[p*AW +: AW]    = pa[p];
        assign wr_data[p*DW +: DW] = pd[p];
    end

    mtx_bank i_mtx_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(pwe), .rd_en(pre),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic bit valid_a(logic [AW-1:0] a);
        return (a[AW-1:12] < NL) && (a[11:0] == 0);
    endfunction

    function automatic int unsigned exp_rd(int p);
        if (!pre[p] || !valid_a(pa[p])) return 0;
        return mdl[pa[p][AW-1:12]];
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(int p, bit we, bit re, int idx, int off, int unsigned d);
        pwe[p] = we;
        pre[p] = re;
        pa[p]  = AW'((idx << 12) + off);
        pd[p]  = d;
    endtask

    task automatic idle();
        for (int p = 0; p < NP; p++) drive(p, 0, 0, 0, 0, 0);
    endtask

    task automatic model_step();
        bit done [NL];
        for (int i = 0; i < NL; i++) done[i] = 0;
        for (int p = 0; p < NP; p++) begin
            if (rst_n && pwe[p] && valid_a(pa[p])) begin
                int i = int'(pa[p][AW-1:12]);
                if (!done[i]) begin
                    done[i] = 1;
                    if (pd[p] == 0) mdl[i] = 0;
                    else if (mdl[i] == 0) mdl[i] = pd[p];
                end
            end
        end
    endtask

    // advance one clock, update the model, compare every read port
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        for (int p = 0; p < NP; p++) check(tag, rd_data[p*DW +: DW], exp_rd(p));
    endtask

    task automatic readback(string tag, int idx, int unsigned exp);
        idle();
        drive(0, 0, 1, idx, 0, 0);
        tick(tag);
        check(tag, rd_data[DW-1:0], exp);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) mdl[i] = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: all locks free after reset
        for (int i = 0; i < NL; i++) readback("R9", i, 0);

        // R2 / R1: claim lock 3 with ID 1 at 3*0x1000
        idle(); drive(0, 1, 1, 3, 0, 1); tick("R2");
        readback("R1", 3, 1);

        // R3: second claimant is ignored
        idle(); drive(1, 1, 0, 3, 0, 2); tick("R3");
        readback("R3", 3, 1);

        // R4: zero from a non-owner port still clears
        idle(); drive(1, 1, 0, 3, 0, 0); tick("R4");
        readback("R4", 3, 0);

        // R5: simultaneous claim, port 0 wins
        idle(); drive(0, 1, 0, 5, 0, 7); drive(1, 1, 0, 5, 0, 9); tick("R5");
        readback("R5", 5, 7);
        // R5: port 0 nonzero (ignored) hides port 1 release
        idle(); drive(0, 1, 0, 5, 0, 4); drive(1, 1, 0, 5, 0, 0); tick("R5");
        readback("R5", 5, 7);

        // R10: different locks in one cycle
        idle(); drive(0, 1, 0, 6, 0, 11); drive(1, 1, 0, 7, 0, 12); tick("R10");
        readback("R10", 6, 11);
        readback("R10", 7, 12);

        // R7: index 32 and 255 do not alias
        idle(); drive(0, 1, 1, 32, 0, 4); drive(1, 1, 1, 255, 0, 5); tick("R7");
        check("R7", rd_data[DW-1:0], 0);
        readback("R7", 0, 0);
        readback("R7", 31, 0);

        // R8: nonzero page offset
        idle(); drive(0, 1, 0, 8, 4, 3); tick("R8");
        readback("R8", 8, 0);
        idle(); drive(0, 1, 0, 8, 0, 3); drive(1, 0, 1, 8, 4, 0); tick("R8");
        check("R8", rd_data[2*DW-1:DW], 0);

        // R6: reads have no side effects; rd_en low gives 0
        idle(); drive(0, 0, 1, 8, 0, 0); drive(1, 0, 1, 8, 0, 0);
        repeat (3) tick("R6");
        check("R6", rd_data[DW-1:0], 3);
        idle(); drive(0, 0, 0, 8, 0, 0); tick("R6");
        check("R6", rd_data[DW-1:0], 0);

        // mixed random traffic against the model
        for (int n = 0; n < 600; n++) begin
            for (int p = 0; p < NP; p++) begin
                int r = int'($urandom % 48);
                drive(p, ($urandom % 2) == 1, ($urandom % 4) != 0,
                      (r < 40) ? r % 10 : 30 + r,
                      (($urandom % 8) == 0) ? 4 : 0, $urandom % 4);
            end
            tick("R2 R3 R4 R5 R6 R7 R8 R10 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule